// File: doc/BRIEF.md
# Quadrature Rotary Encoder Position Decoder

This block turns the two phase-shifted square waves from a mechanical rotary encoder into a signed step count. Both phases are brought onto the system clock through a short synchronizer chain. A last register stage then holds the previous sample of each phase. Every rising and every falling edge of either phase is one step. The direction of a step comes from the level of the opposite phase, so one full signal period yields four counts.

The position is an unsigned register that wraps in both directions. Each accepted step is also reported as a single-clock strobe, so a consumer can follow every step without differencing the position. A simultaneous change of both phases within one sample cannot be decoded. It is flagged with its own strobe and does not move the position. A synchronous clear input zeroes the position.

Top module: `rot_quad_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `pos` is 0 and `step_up`, `step_dn` and `bad_step` are 0. The phase history resets to A=0, B=0.
- R2: An up step (pos+1, `step_up` high) results from a rising B edge with A=0, a rising A edge with B=1, a falling B edge with A=1, or a falling A edge with B=0.
- R3: A down step (pos-1, `step_dn` high) results from a rising A edge with B=0, a rising B edge with A=1, a falling A edge with B=1, or a falling B edge with A=0.
- R4: One full forward period of the phases (AB = 00,01,11,10,00) adds exactly 4 to `pos`. The reverse order subtracts exactly 4.
- R5: If both phases differ from their previous sample at once, `bad_step` is high for that one clock and `pos` is unchanged.
- R6: `pos` is POS_W bits wide (default 8) and wraps modulo 2^POS_W: 255+1 gives 0 and 0-1 gives 255.
- R7: `clr` high at a rising edge sets `pos` to 0 at that edge and suppresses all three strobes, even when a step is decoded in the same cycle.
- R8: A phase change set up before rising edge k shows on `pos` and the strobes after edge k+2 (two synchronizer stages, one count stage).
- R9: At most one of `step_up`, `step_dn` and `bad_step` is high in any cycle.
- R10: While neither phase changes and `clr` is low, `pos` holds and all strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| clr | input | 1 | Synchronous clear of the position |
| ph_a | input | 1 | Encoder phase A, asynchronous |
| ph_b | input | 1 | Encoder phase B, asynchronous |
| pos | output | POS_W | Current position count |
| step_up | output | 1 | One-clock strobe for an up step |
| step_dn | output | 1 | One-clock strobe for a down step |
| bad_step | output | 1 | One-clock strobe when both phases changed in one sample |

## Verification
A wrong previous-sample register shows in the very next cycle. It produces a spurious strobe and a one-count jump in `pos`, or it drops a step so that a full period sums to less than 4. A direction decode error reverses the sign of a strobe three clocks after the phase change. The count is cumulative, so any single lost or extra step persists in `pos` from then on. The bench's per-clock comparison therefore catches it on the first affected cycle and on every later one.

// File: rtl/rqd_pkg.sv
package rqd_pkg;
  typedef enum logic [1:0] {
    MV_NONE = 2'b00,
    MV_UP   = 2'b01,
    MV_DN   = 2'b10,
    MV_BAD  = 2'b11
  } move_e;
endpackage

// File: rtl/rqd_sync.sv
module rqd_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [W-1:0] stg_d;
      if (i == 0) begin : g_first
        always_comb stg_d = d;
      end else begin : g_next
        always_comb stg_d = stg_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rqd_edge_dir.sv
module rqd_edge_dir
  import rqd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a_s,
  input  logic  b_s,
  output move_e move
);
  logic a_prev_q, b_prev_q;
  logic a_chg, b_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a_s;
      b_prev_q <= b_s;
    end
  end

  always_comb begin
    a_chg = a_s ^ a_prev_q;
    b_chg = b_s ^ b_prev_q;
    move  = MV_NONE;
    if (a_chg && b_chg)
      move = MV_BAD;
    else if (a_chg)
      move = (a_s == b_s) ? MV_UP : MV_DN;
    else if (b_chg)
      move = (b_s != a_s) ? MV_UP : MV_DN;
  end

  AST_CHANGE_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_s != a_prev_q) || (b_s != b_prev_q)) |-> (move != MV_NONE)); // R2
endmodule

// File: rtl/rqd_pos_count.sv
module rqd_pos_count
  import rqd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  move_e        move,
  output logic [W-1:0] pos,
  output logic         up,
  output logic         dn,
  output logic         bad
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] pos_q, pos_d;
  logic         up_q, up_d, dn_q, dn_d, bad_q, bad_d;
  logic         pos_en;

  always_comb begin
    pos_d  = pos_q;
    pos_en = 1'b0;
    up_d   = 1'b0;
    dn_d   = 1'b0;
    bad_d  = 1'b0;
    if (clr) begin
      pos_d  = '0;
      pos_en = 1'b1;
    end else begin
      case (move)
        MV_UP:   begin pos_d = pos_q + ONE; pos_en = 1'b1; up_d = 1'b1; end
        MV_DN:   begin pos_d = pos_q - ONE; pos_en = 1'b1; dn_d = 1'b1; end
        MV_BAD:  bad_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      if (pos_en) pos_q <= pos_d;
      up_q  <= up_d;
      dn_q  <= dn_d;
      bad_q <= bad_d;
    end
  end

  assign pos = pos_q;
  assign up  = up_q;
  assign dn  = dn_q;
  assign bad = bad_q;

  AST_UP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (pos_q == $past(pos_q) + ONE)); // R2
  AST_DN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    dn_q |-> (pos_q == $past(pos_q) - ONE)); // R3
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pos_q == '0 && !up_q && !dn_q && !bad_q)); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_q, dn_q, bad_q})); // R9
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_q && !dn_q && !$past(clr)) |-> $stable(pos_q)); // R10
endmodule

// File: rtl/rot_quad_decoder.sv
module rot_quad_decoder
  import rqd_pkg::*;
#(
  parameter int POS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ph_a,
  input  logic             ph_b,
  output logic [POS_W-1:0] pos,
  output logic             step_up,
  output logic             step_dn,
  output logic             bad_step
);
  localparam int PH_W = 2;

  logic [PH_W-1:0] ph_s;
  move_e           move;

  rqd_sync #(.STAGES(SYNC_STAGES), .W(PH_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ph_a, ph_b}),
    .q     (ph_s)
  );

  rqd_edge_dir u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .a_s   (ph_s[1]),
    .b_s   (ph_s[0]),
    .move  (move)
  );

  rqd_pos_count #(.W(POS_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .move  (move),
    .pos   (pos),
    .up    (step_up),
    .dn    (step_dn),
    .bad   (bad_step)
  );

  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_step && !$past(clr)) |-> $stable(pos)); // R5
endmodule

// File: tb/tb_rot_quad_decoder.sv
module tb_rot_quad_decoder;
  logic       clk = 1'b0;
  logic       rst_n, clr, ph_a, ph_b;
  logic [7:0] pos;
  logic       step_up, step_dn, bad_step;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  rot_quad_decoder dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ph_a(ph_a), .ph_b(ph_b),
    .pos(pos), .step_up(step_up), .step_dn(step_dn), .bad_step(bad_step)
  );

  // Behavioural reference: a queue holds the last three sampled phase pairs.
  logic [1:0] hist[$];
  int  m_pos;
  bit  m_up, m_dn, m_bad;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{2'b00, 2'b00, 2'b00};
      m_pos = 0; m_up = 0; m_dn = 0; m_bad = 0;
    end else begin
      logic [1:0] o, n;
      o = hist[0];
      n = hist[1];
      m_up = 0; m_dn = 0; m_bad = 0;
      if (clr) begin
        m_pos = 0;
      end else if (o[1] != n[1] && o[0] != n[0]) begin
        m_bad = 1;
      end else if (o[1] != n[1]) begin
        if (n[1] == n[0]) begin m_up = 1; m_pos = (m_pos + 1) % 256; end
        else begin m_dn = 1; m_pos = (m_pos + 255) % 256; end
      end else if (o[0] != n[0]) begin
        if (n[0] != n[1]) begin m_up = 1; m_pos = (m_pos + 1) % 256; end
        else begin m_dn = 1; m_pos = (m_pos + 255) % 256; end
      end
      void'(hist.pop_front());
      hist.push_back({ph_a, ph_b});
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "pos", int'(pos), m_pos);
      check(cur_req, "step_up", int'(step_up), int'(m_up));
      check(cur_req, "step_dn", int'(step_dn), int'(m_dn));
      check(cur_req, "bad_step", int'(bad_step), int'(m_bad));
      check("R9", "strobe count", $countones({step_up, step_dn, bad_step}) <= 1, 1);
    end
  end

  task automatic go(logic a, logic b, int hold);
    ph_a = a; ph_b = b;
    repeat (hold) @(negedge clk);
  endtask

  task automatic fwd_period(int hold);
    go(0, 1, hold); go(1, 1, hold); go(1, 0, hold); go(0, 0, hold);
  endtask

  task automatic rev_period(int hold);
    go(1, 0, hold); go(1, 1, hold); go(0, 1, hold); go(0, 0, hold);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int p0;
    rst_n = 0; clr = 0; ph_a = 0; ph_b = 0;
    repeat (3) @(negedge clk);
    check("R1", "pos in reset", int'(pos), 0);
    check("R1", "strobes in reset", int'({step_up, step_dn, bad_step}), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "pos after release", int'(pos), 0);

    // R8: latency, a change shows after the third rising edge
    cur_req = "R8";
    ph_b = 1;
    @(negedge clk); check("R8", "no step after 1 edge", int'(step_up), 0);
    @(negedge clk); check("R8", "no step after 2 edges", int'(step_up), 0);
    @(negedge clk); check("R8", "step after 3 edges", int'(step_up), 1);
    check("R8", "pos after 3 edges", int'(pos), 1);
    repeat (3) @(negedge clk);

    // R2: the four up conditions, one by one
    cur_req = "R2";
    go(1, 1, 5); check("R2", "rise A B=1", int'(pos), 2);
    go(1, 0, 5); check("R2", "fall B A=1", int'(pos), 3);
    go(0, 0, 5); check("R2", "fall A B=0", int'(pos), 4);

    // R3: the four down conditions
    cur_req = "R3";
    go(1, 0, 5); check("R3", "rise A B=0", int'(pos), 3);
    go(1, 1, 5); check("R3", "rise B A=1", int'(pos), 2);
    go(0, 1, 5); check("R3", "fall A B=1", int'(pos), 1);
    go(0, 0, 5); check("R3", "fall B A=0", int'(pos), 0);

    // R4: four counts per period, fast and slow
    cur_req = "R4";
    p0 = int'(pos);
    fwd_period(4); repeat (3) @(negedge clk);
    check("R4", "forward period", (int'(pos) - p0 + 256) % 256, 4);
    fwd_period(1); repeat (3) @(negedge clk);
    check("R4", "fast forward period", (int'(pos) - p0 + 256) % 256, 8);
    rev_period(2); repeat (3) @(negedge clk);
    check("R4", "reverse period", (int'(pos) - p0 + 256) % 256, 4);

    // R5: both phases change together
    cur_req = "R5";
    p0 = int'(pos);
    go(1, 1, 1); @(negedge clk);
    @(negedge clk); check("R5", "bad strobe", int'(bad_step), 1);
    check("R5", "pos held", int'(pos), p0);
    @(negedge clk); check("R5", "bad strobe one clock", int'(bad_step), 0);
    go(0, 0, 5); check("R5", "pos held after return", int'(pos), p0);

    // R6: wrap down through zero and up through the top
    cur_req = "R6";
    clr = 1; @(negedge clk); clr = 0;
    go(1, 0, 5); check("R6", "0-1 wraps", int'(pos), 255);
    go(0, 0, 5); check("R6", "255+1 wraps", int'(pos), 0);
    for (int i = 0; i < 66; i++) fwd_period(2);
    repeat (3) @(negedge clk);
    check("R6", "264 steps modulo 256", int'(pos), 8);

    // R7: clear in the same cycle as a decoded step
    cur_req = "R7";
    ph_b = 1;
    @(negedge clk); @(negedge clk);
    clr = 1;
    @(negedge clk);
    check("R7", "pos cleared", int'(pos), 0);
    check("R7", "step suppressed", int'(step_up), 0);
    clr = 0;

    // R10: steady phases
    cur_req = "R10";
    repeat (20) @(negedge clk);
    check("R10", "pos steady", int'(pos), 0);

    // R1: async reset in mid-run
    cur_req = "R1";
    go(1, 1, 5);
    rst_n = 0; @(negedge clk);
    check("R1", "pos after mid reset", int'(pos), 0);
    ph_a = 0; ph_b = 0; @(negedge clk);
    rst_n = 1; repeat (5) @(negedge clk);
    check("R1", "quiet after reset", int'(pos), 0);

    summary();
  end
endmodule